// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Sequence Checker

This block watches the command pins of a four-bank double-data-rate SDRAM for one clock at a time. It turns the clock-enable history, chip select, the three strobe lines, the bank pair, the auto-precharge bit and the address into a single command code. It registers that code with the target bank, an all-banks marker and the effective address.

Alongside decoding, it keeps a small model of each bank: idle, open, or open and closing under auto-precharge. From that model it raises a flag on any command that breaks the ordering rules. The rules cover refresh and mode-register writes with a row still open, commands too soon after a mode-register write, column accesses during a write burst with auto-precharge, activating an open bank, and accessing a closed or closing bank. It also keeps the last accepted normal and extended mode-register opcodes. A controller model or a bus monitor can place it on the command bus and read the illegal flag cycle by cycle.

All outputs are registered and appear one clock after the edge that sampled the pins. A command that is flagged illegal has no effect on the bank model, the lockout, the burst window or the stored opcodes.

Top module: `ddr_cmd_checker`

## Requirements
- R1: `cmd_code` uses this encoding: 0 deselect, 1 no-op, 2 mode set, 3 extended mode set, 4 auto refresh, 5 self-refresh entry, 6 activate, 7 read, 8 read with auto-precharge, 9 write, 10 write with auto-precharge, 11 burst stop, 12 precharge. When `cke_prev` is high and `cs_n` is high, the code is 0. When `cke_prev` is low, the code is 1 for any pins. No-op and deselect are never flagged illegal.
- R2: With `cke_prev` high and `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 011 is activate, 101 is read, 100 is write, 110 is burst stop, 010 is precharge, 111 is no-op, 000 is a mode set, and 001 is a refresh.
- R3: A refresh with `cke` high decodes as auto refresh (4). A refresh with `cke` low decodes as self-refresh entry (5).
- R4: `cmd_bank` repeats `ba` as a binary bank number (0 to 3, `ba[1]` the upper bit). `all_banks` is 1 only for a precharge with `ap` high.
- R5: For reads and writes, `ap` high selects the auto-precharge code. `cmd_addr` then carries only the lower COL_W address bits, with the upper bits zero. For every other command `cmd_addr` equals `addr`.
- R6: A mode set with `ba[0]` = 0 is a normal mode set (2), and with `ba[0]` = 1 it is an extended one (3). An accepted one stores {`ap`,`addr`} in `mode_op` or in `emode_op` respectively.
- R7: Mode set, extended mode set, auto refresh and self-refresh entry are flagged illegal while any bank is open.
- R8: For LOCK_CYC cycles after an accepted mode set, every command other than no-op and deselect is flagged illegal.
- R9: After an accepted write with auto-precharge, any read or write issued in the next BURST_LEN/2 cycles is flagged illegal. Reads and writes to other open banks are legal after that.
- R10: Activate to an open bank is illegal. Read or write to an idle bank, or to a bank under auto-precharge, is illegal. Precharge closes the addressed bank, or all banks when `ap` is high.
- R11: A bank accessed with auto-precharge at cycle t stays open through cycle t+BURST_LEN/2+AP_DELAY and accepts an activate from the cycle after that.
- R12: An illegal command changes neither the bank state, nor the lockout, nor the stored opcodes.
- R13: After reset all banks are idle, no lockout or burst window is active, `cmd_code` is 0, `illegal` is 0, and both stored opcodes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_prev | input | 1 | Clock-enable level of the previous cycle |
| cke | input | 1 | Clock-enable level of this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| addr | input | ADDR_W | Row or column address, excluding the auto-precharge bit |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Target bank |
| all_banks | output | 1 | Precharge applies to every bank |
| cmd_addr | output | ADDR_W | Row address, or zero-extended column address |
| illegal | output | 1 | Command breaks an ordering rule |
| mode_op | output | ADDR_W+1 | Last accepted normal mode opcode |
| emode_op | output | ADDR_W+1 | Last accepted extended mode opcode |

## Verification
The embedded assertions check on every cycle that no-ops are never flagged. They also check that a lockout, a running write burst or an open bank produces a flag on the following cycle. The bank model itself is covered too: a bank opens only after an accepted activate, its close counter stays bounded, and an auto-precharge access lands only on an open bank. The exact decode table, the cycles on which a closing bank becomes usable again, and the proof that a rejected command leaves the stored opcodes and lockout untouched can only be shown by the bench's sweeps and sequences.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_MRS   = 4'd2,
      CMD_EMRS  = 4'd3,
      CMD_AREF  = 4'd4,
      CMD_SREF  = 4'd5,
      CMD_ACT   = 4'd6,
      CMD_RD    = 4'd7,
      CMD_RDA   = 4'd8,
      CMD_WR    = 4'd9,
      CMD_WRA   = 4'd10,
      CMD_BST   = 4'd11,
      CMD_PRE   = 4'd12
   } ddr_cmd_e;

   function automatic logic is_idle_cmd(ddr_cmd_e c);
      return (c == CMD_NOP) || (c == CMD_DESEL);
   endfunction

   function automatic logic is_col_cmd(ddr_cmd_e c);
      return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
   endfunction

   function automatic logic needs_all_idle(ddr_cmd_e c);
      return (c == CMD_MRS) || (c == CMD_EMRS) || (c == CMD_AREF) || (c == CMD_SREF);
   endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_cmd_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int COL_W  = 8,
   parameter int BA_W   = 2
) (
   input  logic              cke_prev,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic              ap,
   input  logic [ADDR_W-1:0] addr,
   output ddr_cmd_e          cmd,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              all_sel
);

   localparam int PAD_W = ADDR_W - COL_W;

   logic [ADDR_W-1:0] col_addr;
   assign col_addr = {{PAD_W{1'b0}}, addr[COL_W-1:0]};

   always_comb begin
      cmd      = CMD_NOP;
      eff_addr = addr;
      all_sel  = 1'b0;
      if (!cke_prev) begin
         cmd = CMD_NOP;
      end else if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000: cmd = ba[0] ? CMD_EMRS : CMD_MRS;
            3'b001: cmd = cke ? CMD_AREF : CMD_SREF;
            3'b011: cmd = CMD_ACT;
            3'b101: begin
               cmd      = ap ? CMD_RDA : CMD_RD;
               eff_addr = col_addr;
            end
            3'b100: begin
               cmd      = ap ? CMD_WRA : CMD_WR;
               eff_addr = col_addr;
            end
            3'b110: cmd = CMD_BST;
            3'b010: begin
               cmd     = CMD_PRE;
               all_sel = ap;
            end
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
   parameter int CLOSE_CYC = 4,
   parameter int CLOSE_W   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic pre_i,
   input  logic apre_i,
   output logic open_o,
   output logic closing_o
);

   logic [CLOSE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         cnt_q  <= '0;
      end else if (pre_i) begin
         open_o <= 1'b0;
         cnt_q  <= '0;
      end else if (act_i) begin
         open_o <= 1'b1;
      end else if (apre_i) begin
         cnt_q <= CLOSE_W'(CLOSE_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CLOSE_W'(1)) open_o <= 1'b0;
      end
   end

   assign closing_o = (cnt_q != '0);

   // R10
   open_only_by_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(act_i));

   // R11
   close_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CLOSE_W'(CLOSE_CYC));

   // R10
   apre_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apre_i |-> (open_o && !closing_o));

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
   import ddr_cmd_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 8,
   parameter int BA_W      = 2,
   parameter int BURST_LEN = 4,
   parameter int AP_DELAY  = 2,
   parameter int LOCK_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_prev,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic              ap,
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        cmd_code,
   output logic [BA_W-1:0]   cmd_bank,
   output logic              all_banks,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              illegal,
   output logic [ADDR_W:0]   mode_op,
   output logic [ADDR_W:0]   emode_op
);

   localparam int NBANK     = 1 << BA_W;
   localparam int BURST_CLK = BURST_LEN / 2;
   localparam int CLOSE_CYC = BURST_CLK + AP_DELAY;
   localparam int CLOSE_W   = $clog2(CLOSE_CYC + 1);
   localparam int WB_W      = $clog2(BURST_CLK + 1);
   localparam int LOCK_W    = $clog2(LOCK_CYC + 1);

   generate
      if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("BURST_LEN must be 2, 4 or 8");
      end
      if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_col
         $error("COL_W must be below ADDR_W");
      end
      if (AP_DELAY < 1 || LOCK_CYC < 1) begin : g_bad_dly
         $error("AP_DELAY and LOCK_CYC must be at least 1");
      end
   endgenerate

   // decode
   ddr_cmd_e          d_cmd;
   logic [ADDR_W-1:0] d_addr;
   logic              d_all;

   ddr_cmd_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BA_W(BA_W)) dec_i (
      .cke_prev (cke_prev),
      .cke      (cke),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .ap       (ap),
      .addr     (addr),
      .cmd      (d_cmd),
      .eff_addr (d_addr),
      .all_sel  (d_all)
   );

   // legality
   logic [NBANK-1:0]  bank_open;
   logic [NBANK-1:0]  bank_closing;
   logic [WB_W-1:0]   wb_cnt;
   logic [LOCK_W-1:0] lock_cnt;
   logic              lock_hit, idle_hit, col_hit, act_hit, ill_d, legal;

   always_comb begin
      lock_hit = (lock_cnt != '0) && !is_idle_cmd(d_cmd);
      idle_hit = needs_all_idle(d_cmd) && (|bank_open);
      col_hit  = is_col_cmd(d_cmd) &&
                 ((wb_cnt != '0) || !bank_open[ba] || bank_closing[ba]);
      act_hit  = (d_cmd == CMD_ACT) && bank_open[ba];
      ill_d    = lock_hit || idle_hit || col_hit || act_hit;
      legal    = !ill_d;
   end

   // per-bank state
   logic [NBANK-1:0] act_s, pre_s, apre_s;

   generate
      for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
         logic sel;
         assign sel       = (ba == BA_W'(gb));
         assign act_s[gb] = legal && (d_cmd == CMD_ACT) && sel;
         assign pre_s[gb] = legal && (d_cmd == CMD_PRE) && (d_all || sel);
         assign apre_s[gb] = legal && ((d_cmd == CMD_RDA) || (d_cmd == CMD_WRA)) && sel;

         ddr_bank_tracker #(.CLOSE_CYC(CLOSE_CYC), .CLOSE_W(CLOSE_W)) trk_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_s[gb]),
            .pre_i     (pre_s[gb]),
            .apre_i    (apre_s[gb]),
            .open_o    (bank_open[gb]),
            .closing_o (bank_closing[gb])
         );
      end
   endgenerate

   // write-burst window and mode-register lockout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_cnt   <= '0;
         lock_cnt <= '0;
      end else begin
         if (legal && d_cmd == CMD_WRA) wb_cnt <= WB_W'(BURST_CLK);
         else if (wb_cnt != '0)         wb_cnt <= wb_cnt - 1'b1;

         if (legal && (d_cmd == CMD_MRS || d_cmd == CMD_EMRS)) lock_cnt <= LOCK_W'(LOCK_CYC);
         else if (lock_cnt != '0)                              lock_cnt <= lock_cnt - 1'b1;
      end
   end

   // registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_code  <= CMD_DESEL;
         cmd_bank  <= '0;
         all_banks <= 1'b0;
         cmd_addr  <= '0;
         illegal   <= 1'b0;
         mode_op   <= '0;
         emode_op  <= '0;
      end else begin
         cmd_code  <= d_cmd;
         cmd_bank  <= ba;
         all_banks <= d_all;
         cmd_addr  <= d_addr;
         illegal   <= ill_d;
         if (legal && d_cmd == CMD_MRS)  mode_op  <= {ap, addr};
         if (legal && d_cmd == CMD_EMRS) emode_op <= {ap, addr};
      end
   end

   // R1
   nop_never_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_NOP || cmd_code == CMD_DESEL) |-> !illegal);

   // R8
   lockout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_cnt != '0) && !is_idle_cmd(d_cmd)) |=> illegal);

   // R7
   idle_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (needs_all_idle(d_cmd) && (|bank_open)) |=> illegal);

   // R9
   wburst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wb_cnt != '0) && is_col_cmd(d_cmd)) |=> illegal);

   // R8
   lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_cnt <= LOCK_W'(LOCK_CYC));

endmodule

// File: tb/ddr_cmd_checker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_checker_tb_top;

   localparam int ADDR_W = 12;
   localparam int COL_W  = 8;
   localparam int BC     = 2;   // BURST_LEN/2 at default
   localparam int AD     = 2;   // AP_DELAY
   localparam int LK     = 2;   // LOCK_CYC

   localparam int C_DESEL = 0, C_NOP = 1, C_MRS = 2, C_EMRS = 3, C_AREF = 4,
                  C_SREF = 5, C_ACT = 6, C_RD = 7, C_RDA = 8, C_WR = 9,
                  C_WRA = 10, C_BST = 11, C_PRE = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic cke_prev, cke, cs_n, ras_n, cas_n, we_n, ap;
   logic [1:0] ba;
   logic [ADDR_W-1:0] addr;
   logic [3:0] cmd_code;
   logic [1:0] cmd_bank;
   logic all_banks, illegal;
   logic [ADDR_W-1:0] cmd_addr;
   logic [ADDR_W:0] mode_op, emode_op;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ddr_cmd_checker dut_i (
      .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .addr(addr),
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .all_banks(all_banks),
      .cmd_addr(cmd_addr), .illegal(illegal), .mode_op(mode_op), .emode_op(emode_op)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive raw pins at the falling edge, sample just after the next rising edge
   task automatic pins(input bit ckp, input bit ck, input bit cs, input bit r,
                       input bit c, input bit w, input int b, input bit a, input int ad);
      @(negedge clk);
      cke_prev = ckp; cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
      ba = b[1:0]; ap = a; addr = ad[ADDR_W-1:0];
      @(posedge clk);
      #1;
   endtask

   task automatic send(input int code, input int b, input bit a, input int ad);
      case (code)
         C_MRS:  pins(1, 1, 0, 0, 0, 0, b & 2, a, ad);
         C_EMRS: pins(1, 1, 0, 0, 0, 0, b | 1, a, ad);
         C_AREF: pins(1, 1, 0, 0, 0, 1, b, a, ad);
         C_SREF: pins(1, 0, 0, 0, 0, 1, b, a, ad);
         C_ACT:  pins(1, 1, 0, 0, 1, 1, b, a, ad);
         C_RD:   pins(1, 1, 0, 1, 0, 1, b, 0, ad);
         C_RDA:  pins(1, 1, 0, 1, 0, 1, b, 1, ad);
         C_WR:   pins(1, 1, 0, 1, 0, 0, b, 0, ad);
         C_WRA:  pins(1, 1, 0, 1, 0, 0, b, 1, ad);
         C_BST:  pins(1, 1, 0, 1, 1, 0, b, a, ad);
         C_PRE:  pins(1, 1, 0, 0, 1, 0, b, a, ad);
         C_DESEL: pins(1, 1, 1, 1, 1, 1, b, a, ad);
         default: pins(1, 1, 0, 1, 1, 1, b, a, ad);
      endcase
   endtask

   task automatic send_chk(input string req, input int code, input int b,
                           input bit a, input int exp_ill);
      send(code, b, a, 0);
      check(req, illegal, exp_ill);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cke_prev = 1; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
      ba = 0; ap = 0; addr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int exp_code(bit ckp, bit ck, bit cs, int rcw, bit b0, bit a);
      if (!ckp) return C_NOP;
      if (cs) return C_DESEL;
      case (rcw)
         0: return b0 ? C_EMRS : C_MRS;
         1: return ck ? C_AREF : C_SREF;
         3: return C_ACT;
         5: return a ? C_RDA : C_RD;
         4: return a ? C_WRA : C_WR;
         6: return C_BST;
         2: return C_PRE;
         default: return C_NOP;
      endcase
   endfunction

   initial begin
      do_reset();
      #1;
      // R13 reset state
      check("R13 code", cmd_code, C_DESEL);
      check("R13 illegal", illegal, 0);
      check("R13 mode_op", mode_op, 0);
      check("R13 emode_op", emode_op, 0);

      // R1 R2 R3 R4 R5 decode sweep over pins and both ap levels
      for (int ck2 = 0; ck2 < 4; ck2++)
         for (int cs = 0; cs < 2; cs++)
            for (int rcw = 0; rcw < 8; rcw++)
               for (int a = 0; a < 2; a++) begin
                  int e, eaddr, bk;
                  bk = (rcw + cs + a) & 3;
                  pins(ck2[1], ck2[0], cs[0], rcw[2], rcw[1], rcw[0], bk, a[0], 12'hA5C);
                  e = exp_code(ck2[1], ck2[0], cs[0], rcw, bk[0], a[0]);
                  eaddr = (e >= C_RD && e <= C_WRA) ? (12'hA5C % (1 << COL_W)) : 12'hA5C;
                  check("R2 sweep code", cmd_code, e);
                  check("R4 sweep bank", cmd_bank, bk);
                  check("R4 sweep all", all_banks, (e == C_PRE && a == 1) ? 1 : 0);
                  check("R5 sweep addr", cmd_addr, eaddr);
                  if (e == C_NOP || e == C_DESEL) check("R1 nop legal", illegal, 0);
               end

      do_reset();
      // R10 bank rules
      send_chk("R10 read idle bank", C_RD, 0, 0, 1);
      send_chk("R10 activate idle", C_ACT, 0, 0, 0);
      send_chk("R10 activate open", C_ACT, 0, 0, 1);
      send_chk("R10 read open", C_RD, 0, 0, 0);
      send_chk("R10 write other idle", C_WR, 3, 0, 1);
      send_chk("R10 burst stop", C_BST, 0, 0, 0);
      // R7 with bank 0 open; R12 rejected mode set leaves no trace
      send(C_MRS, 0, 1, 12'h3C3);
      check("R7 mode set with open bank", illegal, 1);
      check("R12 mode_op kept", mode_op, 0);
      send_chk("R12 no lockout after rejected", C_ACT, 1, 0, 0);
      send_chk("R7 auto refresh open", C_AREF, 0, 0, 1);
      send_chk("R7 self refresh open", C_SREF, 0, 0, 1);
      check("R3 self refresh code", cmd_code, C_SREF);
      // precharge single bank then all
      send_chk("R10 precharge bank1", C_PRE, 1, 0, 0);
      send_chk("R10 bank1 closed", C_RD, 1, 0, 1);
      send_chk("R10 bank0 still open", C_RD, 0, 0, 0);
      send_chk("R10 precharge all", C_PRE, 2, 1, 0);
      check("R4 precharge all flag", all_banks, 1);
      send_chk("R7 auto refresh idle", C_AREF, 0, 0, 0);
      send_chk("R7 self refresh idle", C_SREF, 0, 0, 0);

      // R6 R8 mode set and lockout
      send(C_MRS, 0, 1, 12'h123);
      check("R6 mode code", cmd_code, C_MRS);
      check("R7 mode set idle legal", illegal, 0);
      check("R6 mode_op", mode_op, (1 << ADDR_W) | 12'h123);
      for (int k = 1; k <= LK; k++) send_chk("R8 lockout", C_ACT, 2, 0, 1);
      send_chk("R8 lockout over", C_ACT, 2, 0, 0);
      send_chk("R10 precharge all again", C_PRE, 0, 1, 0);
      send(C_EMRS, 0, 0, 12'h055);
      check("R6 extended code", cmd_code, C_EMRS);
      check("R6 emode_op", emode_op, 12'h055);
      check("R6 mode_op unchanged", mode_op, (1 << ADDR_W) | 12'h123);
      send_chk("R8 nop in lockout", C_NOP, 0, 0, 0);
      send_chk("R8 deselect in lockout", C_DESEL, 0, 0, 0);
      send_chk("R8 cleared", C_ACT, 0, 0, 0);

      // R9 R11 write burst with auto-precharge
      send_chk("R9 open bank1", C_ACT, 1, 0, 0);
      send_chk("R9 write ap", C_WRA, 0, 1, 0);
      for (int k = 1; k <= BC; k++) send_chk("R9 column in burst", (k == 1) ? C_RD : C_WR, 1, 0, 1);
      send_chk("R9 other bank after burst", C_RD, 1, 0, 0);
      for (int k = BC + 2; k <= BC + AD; k++) send_chk("R11 bank still closing", C_ACT, 0, 0, 1);
      send_chk("R11 bank idle again", C_ACT, 0, 0, 0);
      // R11 read auto-precharge closes too; R10 access to closing bank
      send_chk("R11 read ap", C_RDA, 1, 1, 0);
      send_chk("R10 read closing bank", C_RD, 1, 0, 1);
      for (int k = 2; k <= BC + AD; k++) send(C_NOP, 0, 0, 0);
      send_chk("R11 activate after read ap", C_ACT, 1, 0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule